// File: doc/BRIEF.md
# Nine-Bit Serial Panel Command Sequencer

This block brings a small display panel controller up and takes it down again without software help. It is a serial master that owns a clock line, a data-out line and an active-low select. Every transfer word it sends is nine bits wide. The top bit of each word tells the panel whether the remaining eight bits are a command or a parameter.

A start request plays a fixed power-up script held in an internal ROM. The script begins with three lone `0x00` commands, each followed by a pause of at least one millisecond. It then writes the controller's setup registers and ends with the display-on command `0x29`. A stop request plays a short power-down script. The host sees `busy` while a script runs and a one-cycle `done` when it completes. A fault reported during the opening reset commands aborts the script and raises `err`.

Top module: `panel_seq`

## Requirements
- R1: Each word is nine bits and is shifted out most significant bit first. Bit 8 of the word is 0 for a command byte and 1 for a parameter byte. Bits 7..0 carry the byte.
- R2: The clock idles high whenever select is high. The data line changes only while the clock is low or idle, and the receiver samples it on the clock's rising edge. Each clock phase lasts `SCLK_HALF` system cycles.
- R3: Select stays low across one whole register write, meaning the command word and all of its parameter words. Select returns high between writes.
- R4: A 16-bit register value is sent as two parameter words: the upper byte first, then the lower byte.
- R5: The start script sends exactly these writes, in this order:
  - `00`, `00`, `00`
  - `B0`←`17`, `BC`←`80`, `3B`←`00`, `B0`←`16`
  - `B8`←`FFF9`
  - `11`
  - `BA`←`01`, `3A`←`60`
  - `EC`←`01F0`
  - `29`
- R6: After each of the three opening `00` commands, at least `CLK_HZ/1000` system cycles pass between select rising and select falling again.
- R7: The stop script sends exactly these writes, in this order: `28`, then `B8`←`8002`, then `10`, then `B0`←`00`.
- R8: `link_fault` high during the reset phase aborts the script. The reset phase runs from acceptance of a start request until the first setup write begins. On abort, select goes high, no further words are sent, `done` does not pulse, `err` is set and `busy` drops. Outside the reset phase, `link_fault` has no effect.
- R9: Requests that arrive while `busy` is high are ignored. If `start_req` and `stop_req` arrive together while idle, the start script runs. Any accepted request clears `err`.
- R10: `done` is high for exactly one cycle when a script finishes, and `busy` is already low in that cycle. After reset the outputs are select high, clock high, `busy`/`done`/`err` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Request the power-up script |
| stop_req | input | 1 | Request the power-down script |
| link_fault | input | 1 | Transfer fault indication, honoured in the reset phase |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low panel select |
| busy | output | 1 | A script is running |
| done | output | 1 | One-cycle pulse at script completion |
| err | output | 1 | Last script aborted on a fault |

## Verification
The bench decodes the serial lines with a receiver model that samples on the rising clock. It compares every frame, word by word, against expected lists built from the register values. The 16-bit values are split arithmetically in the bench, so byte order and the command/parameter tag are both exercised.

The scripts are run in several situations:
- a plain start;
- a plain stop;
- a start and stop raised together;
- requests poked in mid-script.

These runs separate correct script selection and busy-ignore from a design that restarts or switches scripts. Two fault runs are also made. One places the fault inside the reset gap and one places it after the setup writes begin, which distinguishes correct phase gating from a fault check that is always or never active. The measured select gaps confirm the millisecond waits.

// File: rtl/panel_seq_pkg.sv
package panel_seq_pkg;

  localparam int ROM_AW    = 5;
  localparam int SHUT_BASE = 24;

  // one script step: end-of-script, millisecond hold after, last word of write, 9-bit word
  typedef struct packed {
    logic       eos;
    logic       hold;
    logic       last;
    logic [8:0] word;
  } step_t;

  function automatic step_t mk(input logic e, input logic h, input logic l,
                               input logic par, input logic [7:0] b);
    step_t s;
    s.eos  = e;
    s.hold = h;
    s.last = l;
    s.word = {par, b};
    return s;
  endfunction

  // script ROM: start script at 0, stop script at SHUT_BASE
  function automatic step_t script_rom(input logic [ROM_AW-1:0] a);
    case (a)
      5'd0, 5'd1, 5'd2: return mk(1'b0, 1'b1, 1'b1, 1'b0, 8'h00);
      5'd3:  return mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hB0);
      5'd4:  return mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h17);
      5'd5:  return mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hBC);
      5'd6:  return mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h80);
      5'd7:  return mk(1'b0, 1'b0, 1'b0, 1'b0, 8'h3B);
      5'd8:  return mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h00);
      5'd9:  return mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hB0);
      5'd10: return mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h16);
      5'd11: return mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hB8);
      5'd12: return mk(1'b0, 1'b0, 1'b0, 1'b1, 8'hFF);
      5'd13: return mk(1'b0, 1'b0, 1'b1, 1'b1, 8'hF9);
      5'd14: return mk(1'b0, 1'b0, 1'b1, 1'b0, 8'h11);
      5'd15: return mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hBA);
      5'd16: return mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h01);
      5'd17: return mk(1'b0, 1'b0, 1'b0, 1'b0, 8'h3A);
      5'd18: return mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h60);
      5'd19: return mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hEC);
      5'd20: return mk(1'b0, 1'b0, 1'b0, 1'b1, 8'h01);
      5'd21: return mk(1'b0, 1'b0, 1'b1, 1'b1, 8'hF0);
      5'd22: return mk(1'b1, 1'b0, 1'b1, 1'b0, 8'h29);
      5'd24: return mk(1'b0, 1'b0, 1'b1, 1'b0, 8'h28);
      5'd25: return mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hB8);
      5'd26: return mk(1'b0, 1'b0, 1'b0, 1'b1, 8'h80);
      5'd27: return mk(1'b0, 1'b0, 1'b1, 1'b1, 8'h02);
      5'd28: return mk(1'b0, 1'b0, 1'b1, 1'b0, 8'h10);
      5'd29: return mk(1'b0, 1'b0, 1'b0, 1'b0, 8'hB0);
      5'd30: return mk(1'b1, 1'b0, 1'b1, 1'b1, 8'h00);
      default: return mk(1'b1, 1'b0, 1'b1, 1'b0, 8'h00);
    endcase
  endfunction

endpackage

// File: rtl/panel_seq_gap.sv
module panel_seq_gap #(
  parameter int CYCLES = 50000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic go,
  output logic done
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        if (cnt == CW'(CYCLES - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R6: the wait completes only after the counter has been running
  assert_gap_ends_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !run);

endmodule

// File: rtl/panel_seq_spi.sv
module panel_seq_spi #(
  parameter int SCLK_HALF = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kill,
  input  logic       go,
  input  logic [8:0] word,
  input  logic       last,
  output logic       sclk,
  output logic       mosi,
  output logic       cs_n,
  output logic       done
);
  localparam int DW = $clog2(SCLK_HALF + 1);

  typedef enum logic [2:0] {T_IDLE, T_LEAD, T_LOW, T_HIGH, T_TAIL} tx_st_t;

  tx_st_t        st;
  logic [DW-1:0] divc;
  logic [3:0]    bitc;
  logic [8:0]    sh;
  logic          last_q;
  logic          half_end;

  assign half_end = (divc == DW'(SCLK_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || kill) begin
      st     <= T_IDLE;
      divc   <= '0;
      bitc   <= '0;
      sh     <= '0;
      last_q <= 1'b0;
      sclk   <= 1'b1;
      mosi   <= 1'b0;
      cs_n   <= 1'b1;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == T_IDLE) begin
        if (go) begin
          cs_n   <= 1'b0;
          sh     <= word;
          mosi   <= word[8];
          last_q <= last;
          divc   <= '0;
          bitc   <= '0;
          st     <= T_LEAD;
        end
      end else if (!half_end) begin
        divc <= divc + 1'b1;
      end else begin
        divc <= '0;
        case (st)
          T_LEAD: begin
            sclk <= 1'b0;
            st   <= T_LOW;
          end
          T_LOW: begin
            sclk <= 1'b1;
            st   <= T_HIGH;
          end
          T_HIGH: begin
            if (bitc == 4'd8) begin
              st <= T_TAIL;
            end else begin
              bitc <= bitc + 1'b1;
              sh   <= {sh[7:0], 1'b0};
              mosi <= sh[7];
              sclk <= 1'b0;
              st   <= T_LOW;
            end
          end
          default: begin
            if (last_q) cs_n <= 1'b1;
            done <= 1'b1;
            st   <= T_IDLE;
          end
        endcase
      end
    end
  end

  // R2: clock parks high whenever the panel is deselected
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  // R2: data is steady across each rising clock edge
  assert_setup_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(mosi));

  // R1: a word completes with the clock back high after its ninth bit
  assert_word_end_R1: assert property (@(posedge clk) disable iff (rst)
    done |-> sclk);

endmodule

// File: rtl/panel_seq.sv
module panel_seq
  import panel_seq_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int SCLK_HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_req,
  input  logic stop_req,
  input  logic link_fault,
  output logic sclk,
  output logic mosi,
  output logic cs_n,
  output logic busy,
  output logic done,
  output logic err
);
  localparam int MS_RAW    = CLK_HZ / 1000;
  localparam int MS_CYCLES = (MS_RAW < 1) ? 1 : MS_RAW;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_ISSUE, S_SEND, S_GAP} seq_st_t;

  seq_st_t           st;
  logic [ROM_AW-1:0] ptr;
  step_t             step_q;
  logic              rphase;
  logic              tx_go;
  logic              tx_done;
  logic              gap_go;
  logic              gap_done;
  logic              abort;

  assign abort = (st != S_IDLE) && rphase && link_fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      ptr    <= '0;
      step_q <= '0;
      rphase <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      tx_go  <= 1'b0;
      gap_go <= 1'b0;
    end else begin
      done   <= 1'b0;
      tx_go  <= 1'b0;
      gap_go <= 1'b0;
      if (abort) begin
        st     <= S_IDLE;
        busy   <= 1'b0;
        err    <= 1'b1;
        rphase <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            if (start_req || stop_req) begin
              ptr    <= start_req ? '0 : ROM_AW'(SHUT_BASE);
              rphase <= start_req;
              busy   <= 1'b1;
              err    <= 1'b0;
              st     <= S_FETCH;
            end
          end
          S_FETCH: begin
            step_q <= script_rom(ptr);
            st     <= S_ISSUE;
          end
          S_ISSUE: begin
            tx_go <= 1'b1;
            if (!step_q.hold) rphase <= 1'b0;
            st <= S_SEND;
          end
          S_SEND: begin
            if (tx_done) begin
              if (step_q.eos) begin
                st   <= S_IDLE;
                busy <= 1'b0;
                done <= 1'b1;
              end else if (step_q.hold) begin
                gap_go <= 1'b1;
                st     <= S_GAP;
              end else begin
                ptr <= ptr + 1'b1;
                st  <= S_FETCH;
              end
            end
          end
          default: begin
            if (gap_done) begin
              ptr <= ptr + 1'b1;
              st  <= S_FETCH;
            end
          end
        endcase
      end
    end
  end

  panel_seq_spi #(.SCLK_HALF(SCLK_HALF)) u_spi (
    .clk  (clk),
    .rst  (rst),
    .kill (abort),
    .go   (tx_go),
    .word (step_q.word),
    .last (step_q.last),
    .sclk (sclk),
    .mosi (mosi),
    .cs_n (cs_n),
    .done (tx_done)
  );

  panel_seq_gap #(.CYCLES(MS_CYCLES)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .clr  (abort),
    .go   (gap_go),
    .done (gap_done)
  );

  // R10: completion is a single-cycle pulse
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R10: busy has already dropped when done is shown
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: after an abort the panel stays deselected
  assert_err_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> cs_n);

  // R9: a running script keeps running when a new request arrives without a fault
  assert_ignore_req_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && !done && (st != S_SEND) && (st != S_IDLE) && !abort) |=> busy);

endmodule

// File: tb/panel_seq_test.sv
module panel_seq_test;
  localparam int PERIOD   = 10;
  localparam int T_CLK_HZ = 20000;
  localparam int T_HALF   = 2;
  localparam int MS       = T_CLK_HZ / 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_req = 1'b0;
  logic stop_req = 1'b0;
  logic link_fault = 1'b0;
  logic sclk, mosi, cs_n, busy, done, err;

  int checks = 0;
  int errors = 0;

  panel_seq #(.CLK_HZ(T_CLK_HZ), .SCLK_HALF(T_HALF)) uut (
    .clk(clk), .rst(rst), .start_req(start_req), .stop_req(stop_req),
    .link_fault(link_fault), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .busy(busy), .done(done), .err(err)
  );

  always #(PERIOD/2) clk = ~clk;

  // receiver model
  logic [8:0] rx_w [0:31][0:2];
  int rx_len [0:31];
  int nf = 0;
  int cur_len = 0;
  int bits = 0;
  int odd_bits = 0;
  logic [8:0] rsh = '0;
  longint t_rise = 0;
  longint gaps [0:3];
  bit rec_en = 1'b0;

  always @(negedge cs_n) if (rec_en) begin
    cur_len = 0;
    bits = 0;
    if (nf >= 1 && nf <= 3) gaps[nf-1] = ($time - t_rise) / PERIOD;
  end

  always @(posedge sclk) if (rec_en && !cs_n) begin
    rsh = {rsh[7:0], mosi};
    bits++;
    if (bits == 9) begin
      if (nf < 32 && cur_len < 3) rx_w[nf][cur_len] = rsh;
      cur_len++;
      bits = 0;
    end
  end

  always @(posedge cs_n) if (rec_en) begin
    if (bits != 0) odd_bits++;
    if (nf < 32) rx_len[nf] = cur_len;
    nf++;
    t_rise = $time;
  end

  int done_cnt = 0;
  int done_busy = 0;
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (done && busy) done_busy++;
  end

  // expected frames
  logic [8:0] e_w [0:31][0:2];
  int e_len [0:31];
  int ne = 0;

  task automatic e_clear(); ne = 0; endtask
  task automatic e0(input logic [7:0] c);
    e_w[ne][0] = {1'b0, c}; e_len[ne] = 1; ne++;
  endtask
  task automatic e1(input logic [7:0] c, input logic [7:0] v);
    e_w[ne][0] = {1'b0, c}; e_w[ne][1] = {1'b1, v}; e_len[ne] = 2; ne++;
  endtask
  task automatic e2(input logic [7:0] c, input int v);
    e_w[ne][0] = {1'b0, c};
    e_w[ne][1] = {1'b1, 8'((v >> 8) & 255)};
    e_w[ne][2] = {1'b1, 8'(v & 255)};
    e_len[ne] = 3; ne++;
  endtask

  task automatic exp_start();
    e_clear();
    for (int i = 0; i < 3; i++) e0(8'h00);
    e1(8'hB0, 8'h17); e1(8'hBC, 8'h80); e1(8'h3B, 8'h00); e1(8'hB0, 8'h16);
    e2(8'hB8, 16'hFFF9); e0(8'h11);
    e1(8'hBA, 8'h01); e1(8'h3A, 8'h60); e2(8'hEC, 16'h01F0); e0(8'h29);
  endtask

  task automatic exp_stop();
    e_clear();
    e0(8'h28); e2(8'hB8, 16'h8002); e0(8'h10); e1(8'hB0, 8'h00);
  endtask

  task automatic chk(input string req, input bit ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cmp_frames(input string req);
    chk(req, nf == ne, nf, ne);
    chk("R1", odd_bits == 0, odd_bits, 0);
    for (int k = 0; k < ne && k < nf; k++) begin
      chk("R3", rx_len[k] == e_len[k], rx_len[k], e_len[k]);
      for (int j = 0; j < e_len[k] && j < rx_len[k]; j++)
        chk(req, rx_w[k][j] == e_w[k][j], int'(rx_w[k][j]), int'(e_w[k][j]));
    end
  endtask

  task automatic run(input logic s, input logic p, input int fault_at, input int poke_at);
    bit ff = 1'b0;
    bit pf = 1'b0;
    nf = 0; odd_bits = 0; done_cnt = 0; done_busy = 0;
    @(negedge clk); start_req = s; stop_req = p;
    @(negedge clk); start_req = 1'b0; stop_req = 1'b0;
    while (busy) begin
      link_fault = 1'b0; start_req = 1'b0; stop_req = 1'b0;
      if (!ff && nf == fault_at) begin link_fault = 1'b1; ff = 1'b1; end
      if (!pf && nf == poke_at) begin start_req = 1'b1; stop_req = 1'b1; pf = 1'b1; end
      @(negedge clk);
    end
    link_fault = 1'b0; start_req = 1'b0; stop_req = 1'b0;
    repeat (60) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 1'b0, 0, 1);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10", cs_n == 1'b1, cs_n, 1);
    chk("R10", sclk == 1'b1, sclk, 1);
    chk("R10", busy == 1'b0, busy, 0);
    chk("R10", done == 1'b0, done, 0);
    chk("R10", err == 1'b0, err, 0);
    rec_en = 1'b1;

    // R5 / R4 / R6 plain start
    run(1'b1, 1'b0, -1, -1);
    exp_start();
    cmp_frames("R5");
    for (int g = 0; g < 3; g++) chk("R6", gaps[g] >= MS, int'(gaps[g]), MS);
    chk("R10", done_cnt == 1, done_cnt, 1);
    chk("R10", done_busy == 0, done_busy, 0);
    chk("R2", sclk == 1'b1 && cs_n == 1'b1, sclk, 1);

    // R7 plain stop
    run(1'b0, 1'b1, -1, -1);
    exp_stop();
    cmp_frames("R7");
    chk("R10", done_cnt == 1, done_cnt, 1);

    // R9 simultaneous requests pick start; mid-script pokes ignored
    run(1'b1, 1'b1, -1, 8);
    exp_start();
    cmp_frames("R9");
    chk("R9", done_cnt == 1, done_cnt, 1);

    // R9 pokes during stop script are ignored
    run(1'b0, 1'b1, -1, 2);
    exp_stop();
    cmp_frames("R9");

    // R8 fault inside the reset gap aborts
    run(1'b1, 1'b0, 1, -1);
    chk("R8", nf == 1, nf, 1);
    chk("R8", err == 1'b1, err, 1);
    chk("R8", done_cnt == 0, done_cnt, 0);
    chk("R8", cs_n == 1'b1, cs_n, 1);
    chk("R8", busy == 1'b0, busy, 0);

    // R8 fault after setup writes began is ignored, and R9 err cleared by new request
    run(1'b1, 1'b0, 5, -1);
    exp_start();
    cmp_frames("R8");
    chk("R9", err == 1'b0, err, 0);
    chk("R8", done_cnt == 1, done_cnt, 1);

    report();
  end

endmodule